// File: doc/BRIEF.md
# Sampling converter serial readout controller

This block is the digital side of a four-channel, 16-bit sampling converter. It watches a chip-select strobe and a read/convert strobe and works out from their edges and levels whether to start a conversion or to start a readout. While a conversion runs, it pulls an active-low busy flag down. When the conversion ends, it moves the new word into the result register and releases busy. The analog converter is replaced by a stub with a fixed latency. When a conversion starts, the stub captures one of four sample words presented on a bench port, picked by the latched channel address.

The result leaves the block serially, MSB first, in straight binary. In internal-clock mode every accepted conversion start also sends out the previous result on a data clock made inside the block. This clock is a divided copy of the system clock and runs for exactly 16 periods. In external-clock mode a read strobe arms the shifter and the host supplies the data clock. The block answers with a sync pulse that lasts one external clock period, followed by the data bits. A read can come during a conversion, and it then returns the previous word. A read that comes after the conversion returns the new word. A power-down input blocks conversions, and the stored word is kept.

Top module: `adc_serial_ctrl`

## Requirements
- R1: A conversion starts when the read/convert strobe falls while chip select is low, or when chip select falls while read/convert is low. `busy_no` reads 0 in the cycle after the system clock edge that sees the edge.
- R2: `busy_no` stays low for exactly CONV_CYCLES system cycles. It returns high in the cycle in which the new word becomes the stored result.
- R3: A start strobe that arrives while `busy_no` is low is ignored. It does not lengthen the busy time, and the word it would have captured never becomes the result.
- R4: While `pwrdn_i` is high, start strobes do not pull `busy_no` low, and the stored result is kept and can still be read.
- R5: In internal mode (`ext_mode_i` = 0), each accepted conversion start gives exactly 16 rising edges on `dclk_o`. At each rising edge, `data_o` carries one bit of the result stored before that conversion, MSB first. `sync_o` stays low.
- R6: In external mode a readout starts when read/convert rises while chip select is low, or when chip select falls while read/convert is high. `sync_o` is high from the first external clock rise after the readout starts until the second rise.
- R7: In external mode the MSB is on `data_o` after the second external rise. Each later rise shifts out the next bit, and the LSB is on `data_o` after the 17th rise.
- R8: An external readout that starts while a conversion is in progress returns the previous result. A readout that starts after busy is released returns the new result.
- R9: The channel address is captured when both `wr1_ni` and `wr2_ni` are low, and held while either of them is high. Address code n selects channel n+1, which is the word `sample_i[16n+15:16n]`, taken when the conversion starts.
- R10: After reset, `busy_no` is 1, `dclk_o`, `data_o` and `sync_o` are 0, `chan_o` is 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert strobe (low = convert, high = read) |
| pwrdn_i | input | 1 | Power-down; blocks conversions |
| ext_mode_i | input | 1 | 1 = host-supplied data clock, 0 = internal data clock |
| ext_dclk_i | input | 1 | Host data clock, sampled on the system clock |
| wr1_ni | input | 1 | Address write strobe 1, active low |
| wr2_ni | input | 1 | Address write strobe 2, active low |
| addr_i | input | 2 | Channel address code |
| sample_i | input | 64 | Stub sample words, 16 bits for each channel |
| busy_no | output | 1 | Low while a conversion is running |
| dclk_o | output | 1 | Internal data clock (internal mode only) |
| data_o | output | 1 | Serial result, MSB first |
| sync_o | output | 1 | Frame sync, external mode |
| chan_o | output | 2 | Latched channel address |

## Verification
The bench goes after the paths that share one strobe pair. It starts a conversion from both edge orders and a readout from both edge orders. A decoder that mixed them up would start a conversion where a readout is wanted, or shift out data with no sync pulse. It also sends a second start during busy and reads back the first word. A design that restarted would hold busy low for longer or return the later word. A read during a conversion must return the older word, and the internal-clock burst must carry the previous result in exactly 16 edges. A shifter that reloaded at conversion end or miscounted its periods would show up there. Power-down and the address latch holding while a write strobe is high are checked by reading the stored word and the latched channel back at the ports.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  localparam int RES_W = 16;
  localparam int CH_N  = 4;
  localparam int CONV_CYCLES_DEF = 80;
  localparam int DIV_HALF_DEF    = 2;
  localparam int ADDR_W = $clog2(CH_N);
endpackage

// File: rtl/adc_strobe_decode.sv
module adc_strobe_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rc_i,
  output logic conv_req_o,
  output logic read_req_o
);
  logic cs_q, rc_q;
  logic cs_fall, rc_fall, rc_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b1;
      rc_q <= 1'b1;
    end else begin
      cs_q <= cs_ni;
      rc_q <= rc_i;
    end
  end

  assign cs_fall = cs_q & ~cs_ni;
  assign rc_fall = rc_q & ~rc_i;
  assign rc_rise = ~rc_q & rc_i;

  // level of the other strobe picks convert vs read
  assign conv_req_o = (rc_fall & ~cs_ni) | (cs_fall & ~rc_i);
  assign read_req_o = (rc_rise & ~cs_ni) | (cs_fall & rc_i);
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int W           = 16,
  parameter int CH_N        = 4,
  parameter int CONV_CYCLES = 80,
  localparam int AW         = $clog2(CH_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pwrdn_i,
  input  logic [AW-1:0]     chan_i,
  input  logic [CH_N*W-1:0] sample_i,
  output logic              busy_o,
  output logic              go_o,
  output logic [W-1:0]      res_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  hold_q;
  logic          busy_q;

  assign go_o   = start_i & ~busy_q & ~pwrdn_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      res_o  <= '0;
    end else if (go_o) begin
      busy_q <= 1'b1;
      cnt_q  <= C_LAST;
      hold_q <= sample_i[int'(chan_i)*W +: W];
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        res_o  <= hold_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_serializer.sv
module adc_serializer #(
  parameter int W        = 16,
  parameter int DIV_HALF = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_mode_i,
  input  logic         start_int_i,
  input  logic         start_ext_i,
  input  logic         ext_rise_i,
  input  logic [W-1:0] res_i,
  output logic         data_o,
  output logic         dclk_o,
  output logic         sync_o
);
  localparam int CW = $clog2(W + 2);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] BIT_LAST = CW'(W - 1);
  localparam logic [CW-1:0] EXT_SHL  = CW'(W);
  localparam logic [CW-1:0] EXT_END  = CW'(W + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic          active_q;
  logic [W-1:0]  tx_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] div_q;

  assign data_o = active_q & tx_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tx_q     <= '0;
      cnt_q    <= '0;
      div_q    <= '0;
      dclk_o   <= 1'b0;
      sync_o   <= 1'b0;
    end else if (start_int_i || start_ext_i) begin
      active_q <= 1'b1;
      tx_q     <= res_i;
      cnt_q    <= '0;
      div_q    <= '0;
      dclk_o   <= 1'b0;
      sync_o   <= 1'b0;
    end else if (active_q && !ext_mode_i) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!dclk_o) begin
          dclk_o <= 1'b1;
        end else begin
          dclk_o <= 1'b0;
          tx_q   <= {tx_q[W-2:0], 1'b0};
          if (cnt_q == BIT_LAST) active_q <= 1'b0;
          else                   cnt_q    <= cnt_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end else if (active_q && ext_mode_i && ext_rise_i) begin
      // rise 1: sync up; rise 2: sync down, MSB shown; rises 3..W+1 shift
      if (cnt_q == '0)                           sync_o <= 1'b1;
      else if (cnt_q == CW'(1))                  sync_o <= 1'b0;
      else if (cnt_q <= EXT_SHL)                 tx_q   <= {tx_q[W-2:0], 1'b0};
      if (cnt_q == EXT_END) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_serial_pkg::*;
#(
  parameter int CONV_CYCLES = CONV_CYCLES_DEF,
  parameter int DIV_HALF    = DIV_HALF_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  rc_i,
  input  logic                  pwrdn_i,
  input  logic                  ext_mode_i,
  input  logic                  ext_dclk_i,
  input  logic                  wr1_ni,
  input  logic                  wr2_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CH_N*RES_W-1:0] sample_i,
  output logic                  busy_no,
  output logic                  dclk_o,
  output logic                  data_o,
  output logic                  sync_o,
  output logic [ADDR_W-1:0]     chan_o
);
  logic conv_req, read_req, conv_go, busy;
  logic ext_q, ext_rise;
  logic [RES_W-1:0] res;

  adc_strobe_decode u_dec (
    .clk_i, .rst_ni, .cs_ni, .rc_i,
    .conv_req_o(conv_req),
    .read_req_o(read_req)
  );

  // address latch: open while both write strobes low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chan_o <= '0;
    else if (!(wr1_ni | wr2_ni)) chan_o <= addr_i;
  end

  adc_conv_stub #(.W(RES_W), .CH_N(CH_N), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk_i, .rst_ni,
    .start_i (conv_req),
    .pwrdn_i,
    .chan_i  (chan_o),
    .sample_i,
    .busy_o  (busy),
    .go_o    (conv_go),
    .res_o   (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_dclk_i;
  end
  assign ext_rise = ext_dclk_i & ~ext_q;

  adc_serializer #(.W(RES_W), .DIV_HALF(DIV_HALF)) u_ser (
    .clk_i, .rst_ni, .ext_mode_i,
    .start_int_i (conv_go & ~ext_mode_i),
    .start_ext_i (read_req & ext_mode_i),
    .ext_rise_i  (ext_rise),
    .res_i       (res),
    .data_o, .dclk_o, .sync_o
  );

  assign busy_no = ~busy;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwrdn_i,
  input logic          ext_mode_i,
  input logic          wr1_ni,
  input logic          wr2_ni,
  input logic [AW-1:0] addr_i,
  input logic          busy_no,
  input logic          dclk_o,
  input logic          sync_o,
  input logic [AW-1:0] chan_o,
  input logic          conv_go,
  input logic [W-1:0]  res
);
  p_conv_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go |=> !busy_no);

  p_res_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_no && $past(busy_no)) |-> $stable(res));

  p_pwrdn_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrdn_i && busy_no) |=> busy_no);

  p_dclk_int_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> !ext_mode_i);

  p_sync_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> ext_mode_i);

  p_addr_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr1_ni && !wr2_ni) |=> chan_o == $past(addr_i));

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1_ni || wr2_ni) |=> $stable(chan_o));
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.W(adc_serial_pkg::RES_W), .AW(adc_serial_pkg::ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwrdn_i    (pwrdn_i),
  .ext_mode_i (ext_mode_i),
  .wr1_ni     (wr1_ni),
  .wr2_ni     (wr2_ni),
  .addr_i     (addr_i),
  .busy_no    (busy_no),
  .dclk_o     (dclk_o),
  .sync_o     (sync_o),
  .chan_o     (chan_o),
  .conv_go    (conv_go),
  .res        (res)
);

// File: tb/adc_serial_ctrl_tb_top.sv
module adc_serial_ctrl_tb_top;
  localparam int C  = 20;
  localparam int DH = 2;

  typedef struct packed { logic [1:0] a; logic [15:0] w; } vec_t;
  localparam vec_t VEC [6] = '{
    '{2'd0, 16'hA5C3}, '{2'd1, 16'h0001}, '{2'd2, 16'hFFFF},
    '{2'd3, 16'h8000}, '{2'd0, 16'h1234}, '{2'd3, 16'h7FFE}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rc = 1'b0, pwrdn = 1'b0, ext_mode = 1'b1, ext_clk = 1'b0;
  logic wr1 = 1'b1, wr2 = 1'b1;
  logic [1:0] addr = '0;
  logic [63:0] sample = '0;
  logic busy_no, dclk, data, sync;
  logic [1:0] chan;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  adc_serial_ctrl #(.CONV_CYCLES(C), .DIV_HALF(DH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rc_i(rc), .pwrdn_i(pwrdn),
    .ext_mode_i(ext_mode), .ext_dclk_i(ext_clk), .wr1_ni(wr1), .wr2_ni(wr2),
    .addr_i(addr), .sample_i(sample), .busy_no(busy_no), .dclk_o(dclk),
    .data_o(data), .sync_o(sync), .chan_o(chan));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] fill(input logic [1:0] a, input logic [15:0] w);
    logic [63:0] s;
    for (int i = 0; i < 4; i++) s[i*16 +: 16] = (i == int'(a)) ? w : ~w;
    return s;
  endfunction

  task automatic set_addr(input logic [1:0] a);
    addr = a; wr1 = 1'b0; wr2 = 1'b0; tick(1);
    wr1 = 1'b1; wr2 = 1'b1; tick(1);
  endtask

  // cs falls with rc low; returns busy_no one cycle later
  task automatic start_cs(output logic b);
    cs_n = 1'b0; tick(1); b = busy_no;
    cs_n = 1'b1; tick(1);
  endtask

  task automatic ext_clocks(output logic [15:0] w, output logic s1, output logic s2);
    w = '0; s1 = 1'b0; s2 = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      ext_clk = 1'b1; tick(2);
      if (k == 1) s1 = sync;
      if (k == 2) s2 = sync;
      if (k >= 2 && k <= 17) w = {w[14:0], data};
      ext_clk = 1'b0; tick(2);
    end
  endtask

  // read started by cs falling with rc high
  task automatic ext_read(output logic [15:0] w, output logic s1, output logic s2);
    cs_n = 1'b1; tick(1); rc = 1'b1; tick(1); cs_n = 1'b0; tick(1);
    ext_clocks(w, s1, s2);
    cs_n = 1'b1; tick(1); rc = 1'b0; tick(1);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    report();
    $finish;
  end

  initial begin
    logic b, s1, s2, pd;
    logic [15:0] w;
    int rises;
    tick(2); rst_n = 1'b1; tick(1);
    // R10 reset state
    check("R10 busy_no", busy_no, 1); check("R10 dclk", dclk, 0);
    check("R10 data", data, 0);       check("R10 sync", sync, 0);
    check("R10 chan", chan, 0);
    ext_read(w, s1, s2);
    check("R10 result", w, 16'h0000);

    // table: R1 start, R9 channel select, R7 data, R6 sync
    foreach (VEC[i]) begin
      set_addr(VEC[i].a);
      sample = fill(VEC[i].a, VEC[i].w);
      start_cs(b);
      check("R1 busy low", b, 0);
      tick(C + 2);
      ext_read(w, s1, s2);
      check("R9/R7 word", w, VEC[i].w);
      check("R6 sync rise1", s1, 1);
      check("R6 sync rise2", s2, 0);
    end

    // R2 busy duration
    set_addr(2'd1);
    sample = fill(2'd1, 16'h3C3C);
    start_cs(b);
    tick(C - 2);
    check("R2 busy last", busy_no, 0);
    tick(1);
    check("R2 busy released", busy_no, 1);

    // R3 start while busy ignored
    sample = fill(2'd1, 16'h1111);
    start_cs(b);
    tick(3);
    sample = fill(2'd1, 16'h2222);
    start_cs(b);
    tick(C - 7);
    check("R3 busy not extended low", busy_no, 0);
    tick(1);
    check("R3 busy not extended high", busy_no, 1);
    tick(2);
    ext_read(w, s1, s2);
    check("R3 first word kept", w, 16'h1111);

    // R8 read during conversion, then after
    sample = fill(2'd1, 16'hBEEF);
    start_cs(b);
    ext_read(w, s1, s2);
    check("R8 read during conv", w, 16'h1111);
    tick(C);
    ext_read(w, s1, s2);
    check("R8 read after conv", w, 16'hBEEF);

    // R6 rc rising with cs low; R1 rc falling with cs low
    sample = fill(2'd1, 16'h5A01);
    rc = 1'b1; tick(1); cs_n = 1'b0; tick(1);
    rc = 1'b0; tick(1);
    check("R1 rc-fall start", busy_no, 0);
    rc = 1'b1; tick(1);
    ext_clocks(w, s1, s2);
    check("R6 rc-rise read word", w, 16'hBEEF);
    check("R6 rc-rise sync", s1, 1);
    cs_n = 1'b1; tick(1); rc = 1'b0; tick(C);
    ext_read(w, s1, s2);
    check("R6 new word", w, 16'h5A01);

    // R5 internal clock burst carries previous word
    ext_mode = 1'b0;
    sample = fill(2'd1, 16'hC0DE);
    rc = 1'b1; tick(1); cs_n = 1'b0; tick(1);
    rc = 1'b0;
    rises = 0; w = '0; pd = 1'b0; s1 = 1'b0;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      if (dclk && !pd) begin rises++; w = {w[14:0], data}; end
      pd = dclk;
      if (sync) s1 = 1'b1;
    end
    check("R5 edge count", rises, 16);
    check("R5 previous word", w, 16'h5A01);
    check("R5 sync quiet", s1, 0);
    cs_n = 1'b1; tick(1); rc = 1'b0; tick(1);
    ext_mode = 1'b1; tick(1);
    ext_read(w, s1, s2);
    check("R5 new word stored", w, 16'hC0DE);

    // R4 power-down
    pwrdn = 1'b1;
    sample = fill(2'd1, 16'h0F0F);
    start_cs(b);
    check("R4 no busy", b, 1);
    tick(C + 2);
    ext_read(w, s1, s2);
    check("R4 result kept", w, 16'hC0DE);
    pwrdn = 1'b0;

    // R9 latch holds while a write strobe is high
    wr1 = 1'b1; wr2 = 1'b0; addr = 2'd3; tick(2);
    check("R9 hold", chan, 2'd1);
    wr1 = 1'b0; tick(1);
    check("R9 open", chan, 2'd3);
    wr1 = 1'b1; wr2 = 1'b1; tick(1);

    report();
    $finish;
  end
endmodule